// File: doc/BRIEF.md
# Hot-Swap Fault Latch Controller

This block keeps the fault records of a hot-swap power switch controller. Comparators, the current-sense converter and the serial bus sit outside it. Their results arrive as synchronous, active-high single-bit flags, together with a write strobe that carries a data byte for the fault register. Each clock the block captures the live conditions into a STATUS register. It also accumulates them into a sticky FAULT register, which keeps each fault until a defined event clears it.

Several events can clear FAULT. A bus write clears the bits written as zero. A falling switch-on control, a qualified UV reset level or supply lockout wipe the whole register. A falling enable level clears only the four low condition bits and records the enable change in bit 4. A fault whose condition is still live in STATUS cannot be cleared by any of these events. The block also drives a power-good output and a switch hold-off output. The hold-off follows the sticky FAULT bits when auto-retry is off and the live STATUS bits when auto-retry is on.

Top module: `hs_fault_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `status_o` and `fault_o` are zero, `hold_off_o` is 0 and `pgood_o` is 1.
- R2: On the clock edge after `ov_i`, `uv_i` or `oc_i` is sampled high, status bits 0, 1 and 2 respectively equal the sampled levels. Status bit 4 equals the sampled `en_i`. A condition seen high also sets the same FAULT bit, and that bit stays set after the condition ends.
- R3: `sense_hi_i` sampled high while `gate_on_i` is low sets status bit 5 and fault bit 5 at the next edge. With the gate on, the same input sets neither bit.
- R4: Status bit 3 and fault bit 3 (power bad) are set only once `fb_low_i` and `gate_on_i` have been high, with `vgs_low_i` low, for more than 2*CYC_PER_US consecutive cycles. With CYC_PER_US=3, a 6-cycle run sets nothing and a 7-cycle run sets both bits at the 7th edge. `pgood_o` is low exactly while status bit 3 is set.
- R5: One edge after the power-bad condition ends, status bit 3 clears and `pgood_o` returns high, while fault bit 3 stays set.
- R6: A cycle with `wr_en_i` high clears every FAULT bit whose `wr_data_i` bit is 0 and leaves bits written as 1 unchanged.
- R7: No clear event removes a FAULT bit in 0..3 or 5 while the matching `status_o` bit is set. Fault bit 4 has no such protection.
- R8: The whole FAULT register is cleared at the next edge by any of three events: `sw_on_i` falling (sampled high then low), `uvlo_i` high, or `uv_rst_i` held high for more than 2*CYC_PER_US consecutive cycles. A shorter `uv_rst_i` pulse clears nothing.
- R9: When `en_i` falls (sampled high, then low), FAULT bits 0 to 3 clear, FAULT bit 4 is set, and FAULT bit 5 is unchanged.
- R10: When a set and a clear for the same FAULT bit happen in one cycle, the bit is set after the edge.
- R11: With `auto_retry_i` low, `hold_off_o` is the OR of FAULT bits 0..2. With `auto_retry_i` high, it is the OR of STATUS bits 0..2 and the FAULT bits have no effect.
- R12: FAULT bits are never cleared just because their condition ends or auto-retry is enabled. Only the events of R6, R8 and R9 clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ov_i | input | 1 | Overvoltage condition |
| uv_i | input | 1 | Undervoltage condition |
| oc_i | input | 1 | Overcurrent condition |
| sense_hi_i | input | 1 | Current-sense reading at or above the short threshold |
| gate_on_i | input | 1 | Pass-switch gate is driven on |
| fb_low_i | input | 1 | Feedback below power-good threshold |
| vgs_low_i | input | 1 | Gate-to-source voltage low; masks power bad |
| en_i | input | 1 | Card-present enable level |
| sw_on_i | input | 1 | Combined switch-on control |
| uv_rst_i | input | 1 | UV level below its reset threshold |
| uvlo_i | input | 1 | Supply undervoltage lockout |
| auto_retry_i | input | 1 | Auto-retry mode select |
| wr_en_i | input | 1 | FAULT register write strobe |
| wr_data_i | input | 6 | FAULT write data; 0 bits request a clear |
| status_o | output | 6 | Live STATUS register |
| fault_o | output | 6 | Sticky FAULT register |
| hold_off_o | output | 1 | Keep the switch off |
| pgood_o | output | 1 | Power good (low while power bad is live) |

## Verification
The bench builds the block with CYC_PER_US=3, so both 2 µs qualifiers span only six cycles. This keeps the exact boundary within a short directed step: a six-cycle run qualifies nothing and a seven-cycle run qualifies. With windows that short, the bench can also drive random traffic in which qualified power-bad events, UV resets, enable falls and bus writes overlap. The overlaps test the protection and set-wins rules against each other.

// File: rtl/hs_fault_pkg.sv
// Package: bit positions, masks and the clear-request bundle shared by the
// hot-swap fault controller modules.
package hs_fault_pkg;
    localparam int NBITS = 6;
    localparam int B_OV  = 0;
    localparam int B_UV  = 1;
    localparam int B_OC  = 2;
    localparam int B_PB  = 3;
    localparam int B_EN  = 4;
    localparam int B_FS  = 5;

    typedef logic [NBITS-1:0] flag_vec_t;

    // Bits cleared by an enable fall.
    localparam flag_vec_t PART_MASK = 6'b001111;
    // Bits whose live status blocks clearing.
    localparam flag_vec_t PROT_MASK = 6'b101111;
    // Bits that hold the switch off.
    localparam flag_vec_t HOLD_MASK = 6'b000111;

    typedef struct packed {
        logic      full;
        logic      part;
        logic      wr;
        flag_vec_t wr_data;
    } clr_req_t;
endpackage

// File: rtl/hs_qual_timer.sv
// Persistence qualifier: the output is high when the input has been high
// for more than LIMIT consecutive cycles. Assumes a synchronous input.
module hs_qual_timer #(
    parameter int LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic qual_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Count consecutive high cycles, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!in_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Qualified once LIMIT earlier cycles were already high.
    always_comb qual_o = in_i && (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/hs_fault_reg.sv
// Sticky fault register. Clears come in as a request bundle; bits flagged in
// prot_i resist every clear, and set_i wins over any clear in the same cycle.
module hs_fault_reg
    import hs_fault_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_i,
    input  clr_req_t  clr_i,
    input  flag_vec_t prot_i,
    output flag_vec_t fault_o
);
    flag_vec_t clr_mask;
    flag_vec_t fault_q;

    // Merge the three clear sources into one mask, minus protected bits.
    always_comb begin
        clr_mask = '0;
        if (clr_i.full) clr_mask = clr_mask | {NBITS{1'b1}};
        if (clr_i.part) clr_mask = clr_mask | PART_MASK;
        if (clr_i.wr)   clr_mask = clr_mask | ~clr_i.wr_data;
        clr_mask = clr_mask & ~prot_i;
    end

    // Update the register: keep unless cleared, then OR in new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= (fault_q & ~clr_mask) | set_i;
    end

    assign fault_o = fault_q;
endmodule

// File: rtl/hs_holdoff.sv
// Switch hold-off select: sticky faults without auto-retry, live status
// with it. Purely combinational on registered inputs.
module hs_holdoff
    import hs_fault_pkg::*;
(
    input  logic      auto_retry_i,
    input  flag_vec_t status_i,
    input  flag_vec_t fault_i,
    output logic      hold_off_o
);
    // Pick the source vector by mode and reduce the hold bits.
    always_comb begin
        if (auto_retry_i) hold_off_o = |(status_i & HOLD_MASK);
        else              hold_off_o = |(fault_i & HOLD_MASK);
    end
endmodule

// File: rtl/hs_fault_ctrl.sv
// Hot-swap fault latch controller top. Registers live conditions into
// STATUS, feeds sets and clear events to the sticky FAULT register and
// derives power-good and switch hold-off. All inputs are synchronous and
// active high; CYC_PER_US sets the 2 us qualifier length.
module hs_fault_ctrl
    import hs_fault_pkg::*;
#(
    parameter int CYC_PER_US = 125,
    parameter int QUAL_US    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ov_i,
    input  logic       uv_i,
    input  logic       oc_i,
    input  logic       sense_hi_i,
    input  logic       gate_on_i,
    input  logic       fb_low_i,
    input  logic       vgs_low_i,
    input  logic       en_i,
    input  logic       sw_on_i,
    input  logic       uv_rst_i,
    input  logic       uvlo_i,
    input  logic       auto_retry_i,
    input  logic       wr_en_i,
    input  logic [5:0] wr_data_i,
    output logic [5:0] status_o,
    output logic [5:0] fault_o,
    output logic       hold_off_o,
    output logic       pgood_o
);
    localparam int LIMIT = QUAL_US * CYC_PER_US;
    localparam int NQ    = 2;

    logic [NQ-1:0] q_in;
    logic [NQ-1:0] q_out;
    flag_vec_t     cond;
    flag_vec_t     set_vec;
    flag_vec_t     status_q;
    flag_vec_t     fault_w;
    clr_req_t      clr_req;
    logic          en_q;
    logic          on_q;
    logic          en_fall;
    logic          on_fall;

    // Raw persistence inputs: index 0 power bad, index 1 UV reset level.
    always_comb begin
        q_in[0] = fb_low_i && gate_on_i && !vgs_low_i;
        q_in[1] = uv_rst_i;
    end

    for (genvar g = 0; g < NQ; g++) begin : g_qual
        hs_qual_timer #(.LIMIT(LIMIT)) u_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_i   (q_in[g]),
            .qual_o (q_out[g])
        );
    end

    // Previous levels of enable and switch-on, for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            on_q <= 1'b0;
        end else begin
            en_q <= en_i;
            on_q <= sw_on_i;
        end
    end

    // Fall detectors.
    always_comb begin
        en_fall = en_q && !en_i;
        on_fall = on_q && !sw_on_i;
    end

    // Live condition vector that becomes the next STATUS value.
    always_comb begin
        cond       = '0;
        cond[B_OV] = ov_i;
        cond[B_UV] = uv_i;
        cond[B_OC] = oc_i;
        cond[B_PB] = q_out[0];
        cond[B_EN] = en_i;
        cond[B_FS] = sense_hi_i && !gate_on_i;
    end

    // Set vector: conditions, with bit 4 flagging an enable fall instead.
    always_comb begin
        set_vec       = cond;
        set_vec[B_EN] = en_fall;
    end

    // Bundle the clear events for the fault register.
    always_comb begin
        clr_req.full    = on_fall || q_out[1] || uvlo_i;
        clr_req.part    = en_fall;
        clr_req.wr      = wr_en_i;
        clr_req.wr_data = wr_data_i;
    end

    // STATUS register follows the conditions one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= cond;
    end

    hs_fault_reg u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_req),
        .prot_i  (status_q & PROT_MASK),
        .fault_o (fault_w)
    );

    hs_holdoff u_hold (
        .auto_retry_i (auto_retry_i),
        .status_i     (status_q),
        .fault_i      (fault_w),
        .hold_off_o   (hold_off_o)
    );

    assign status_o = status_q;
    assign fault_o  = fault_w;
    assign pgood_o  = !status_q[B_PB];
endmodule

// File: rtl/hs_fault_ctrl_chk.sv
// Assertion checker for hs_fault_ctrl, bound to every instance of the top.
module hs_fault_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ov_i,
    input logic       en_i,
    input logic       uvlo_i,
    input logic       auto_retry_i,
    input logic [5:0] status_o,
    input logic [5:0] fault_o,
    input logic       hold_off_o,
    input logic       pgood_o
);
    p_status_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status_o[0] == $past(ov_i)));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & 6'h2F) & ~fault_o) == 6'h00);

    p_en_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(en_i)) |=> fault_o[4]);

    p_holdoff_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_retry_i && (fault_o[2:0] != 3'b000)) |-> hold_off_o);

    p_pgood_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[3] |-> !pgood_o);

    p_full_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(uvlo_i) && (($past(status_o) & 6'h2F) == 6'h00)
         && ((status_o & 6'h2F) == 6'h00)) |-> ((fault_o & 6'h2F) == 6'h00));
endmodule

bind hs_fault_ctrl hs_fault_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ov_i         (ov_i),
    .en_i         (en_i),
    .uvlo_i       (uvlo_i),
    .auto_retry_i (auto_retry_i),
    .status_o     (status_o),
    .fault_o      (fault_o),
    .hold_off_o   (hold_off_o),
    .pgood_o      (pgood_o)
);

// File: tb/tb_hs_fault_ctrl.sv
// Bench: behavioural per-cycle model compared against the outputs each cycle.
module tb_hs_fault_ctrl;
    localparam int CPU = 3;
    localparam int LIM = 2 * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ov = 0, uv = 0, oc = 0, sense = 0, gate = 0, fb = 0, vgs = 0;
    logic en = 0, swon = 0, uvr = 0, uvlo = 0, ar = 0, wr = 0;
    logic [5:0] wd = '0;
    logic [5:0] status, fault;
    logic hold, pgood;

    int tests = 0, fails = 0, cycles = 0;
    string tag = "R1";

    // model state
    logic [5:0] m_st = '0, m_f = '0;
    int pb_cnt = 0, uvr_cnt = 0;
    logic p_en = 0, p_on = 0;

    always #4 clk = ~clk;

    hs_fault_ctrl #(.CYC_PER_US(CPU)) dut (
        .clk(clk), .rst_n(rst_n), .ov_i(ov), .uv_i(uv), .oc_i(oc),
        .sense_hi_i(sense), .gate_on_i(gate), .fb_low_i(fb), .vgs_low_i(vgs),
        .en_i(en), .sw_on_i(swon), .uv_rst_i(uvr), .uvlo_i(uvlo),
        .auto_retry_i(ar), .wr_en_i(wr), .wr_data_i(wd),
        .status_o(status), .fault_o(fault), .hold_off_o(hold), .pgood_o(pgood)
    );

    task automatic model_edge();
        bit pbc, pbq, uq, efall, ofall, full;
        logic [5:0] setv, nst;
        if (!rst_n) begin
            m_st = '0; m_f = '0; pb_cnt = 0; uvr_cnt = 0; p_en = 0; p_on = 0;
            return;
        end
        pbc = fb && gate && !vgs;
        pbq = pbc && (pb_cnt >= LIM);
        pb_cnt = pbc ? ((pb_cnt < LIM) ? pb_cnt + 1 : LIM) : 0;
        uq = uvr && (uvr_cnt >= LIM);
        uvr_cnt = uvr ? ((uvr_cnt < LIM) ? uvr_cnt + 1 : LIM) : 0;
        efall = p_en && !en;
        ofall = p_on && !swon;
        full = ofall || uq || uvlo;
        nst = {sense && !gate, en, pbq, oc, uv, ov};
        setv = nst; setv[4] = efall;
        for (int i = 0; i < 6; i++) begin
            bit clr, prot;
            clr = full || (efall && i < 4) || (wr && !wd[i]);
            prot = (i != 4) && m_st[i];
            m_f[i] = (m_f[i] && !(clr && !prot)) || setv[i];
        end
        m_st = nst;
        p_en = en; p_on = swon;
    endtask

    task automatic compare();
        logic eh, ep;
        eh = ar ? |m_st[2:0] : |m_f[2:0];
        ep = !m_st[3];
        tests++;
        if (status !== m_st || fault !== m_f || hold !== eh || pgood !== ep) begin
            fails++;
            $display("FAIL %s cycle %0d: status=%b fault=%b hold=%b pgood=%b expected status=%b fault=%b hold=%b pgood=%b",
                     tag, cycles, status, fault, hold, pgood, m_st, m_f, eh, ep);
        end
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_edge();
            cycles++;
            @(negedge clk);
            compare();
        end
    endtask

    task automatic quiet();
        ov = 0; uv = 0; oc = 0; sense = 0; fb = 0; vgs = 0; uvr = 0; uvlo = 0; wr = 0; wd = '1;
    endtask

    task automatic wipe();
        swon = 0; step(1); swon = 1; step(1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wd = '1;
        @(negedge clk);
        tag = "R1"; step(3);
        rst_n = 1; step(1);
        swon = 1; en = 1; gate = 1; step(2);

        tag = "R2"; ov = 1; step(1); ov = 0; uv = 1; step(1); uv = 0; oc = 1; step(2);
        oc = 0; step(2);
        en = 0; step(1); en = 1; step(1); wipe();

        tag = "R3"; sense = 1; step(2); gate = 0; step(2); sense = 0; step(1); gate = 1; step(1);
        wipe();

        tag = "R4"; fb = 1; step(LIM); fb = 0; step(2);
        fb = 1; step(LIM + 1); step(2);
        vgs = 1; step(1);
        tag = "R5"; vgs = 0; fb = 0; step(3);
        tag = "R4"; fb = 1; vgs = 1; step(LIM + 3); fb = 0; vgs = 0; step(1);

        tag = "R6"; ov = 1; oc = 1; step(1); ov = 0; oc = 0; step(1);
        wr = 1; wd = 6'b111110; step(1); wr = 0; wd = '1; step(1);
        wr = 1; wd = 6'b000000; step(1); wr = 0; wd = '1; step(1);

        tag = "R7"; uv = 1; step(2); wr = 1; wd = 6'b000000; step(1); wr = 0; wd = '1;
        uvlo = 1; step(1); uvlo = 0; step(1); uv = 0; step(1);
        wr = 1; wd = 6'b000000; step(1); wr = 0; wd = '1; step(1);

        tag = "R8"; ov = 1; step(1); ov = 0; step(1); swon = 0; step(1); swon = 1; step(1);
        oc = 1; step(1); oc = 0; uvlo = 1; step(1); uvlo = 0; step(1);
        uv = 1; step(1); uv = 0; uvr = 1; step(LIM); uvr = 0; step(2);
        uvr = 1; step(LIM + 1); uvr = 0; step(2);

        tag = "R9"; ov = 1; gate = 0; sense = 1; step(1); ov = 0; sense = 0; gate = 1; step(1);
        en = 0; step(2); en = 1; step(2);

        tag = "R10"; wipe(); ov = 1; wr = 1; wd = 6'b000000; step(1);
        wr = 0; wd = '1; ov = 0; step(1);
        oc = 1; uvlo = 1; step(1); oc = 0; uvlo = 0; step(1);

        tag = "R11"; ar = 0; step(2); ar = 1; step(2); oc = 1; step(2); oc = 0; step(2);
        ar = 0; step(1);

        tag = "R12"; ar = 1; uv = 1; step(3); uv = 0; step(5); ar = 0; step(2);

        tag = "R10"; quiet();
        for (int r = 0; r < 2500; r++) begin
            ov = ($urandom % 8) == 0; uv = ($urandom % 8) == 0; oc = ($urandom % 8) == 0;
            sense = ($urandom % 6) == 0; gate = ($urandom % 10) != 0;
            fb = ($urandom % 10) != 0; vgs = ($urandom % 20) == 0;
            en = ($urandom % 16) != 0; swon = ($urandom % 30) != 0;
            uvr = ($urandom % 4) != 0; uvlo = ($urandom % 60) == 0;
            ar = ($urandom % 50) == 0 ? ~ar : ar;
            wr = ($urandom % 5) == 0; wd = 6'($urandom);
            step(1);
        end
        quiet(); step(2);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule